// File: doc/BRIEF.md
# System Clock Control Register Block

This block is the register file of a chip's system control unit, reached through a plain 32-bit word-addressed write/read port. It holds identification and capability words that are fixed by parameters. It also holds writable configuration words for power monitoring, voltage regulation, reset cause and clock setup. From the active clock divider it produces a registered system clock period in nanoseconds. A small interrupt status word, paired with an enable mask, drives a single interrupt line. Today the only hardware event in that status word is the PLL lock indication.

Two clock configuration words exist: a primary one, and a second one with a wider divider. Setting an override bit in the second word makes its divider the active one. Reading the PLL configuration location returns a word derived from the crystal selection field of the primary word. The formula for that word depends on the device class. Builds for the older class have no working second word.

Reads are combinational and have no side effects. A write takes effect at the clock edge on which it is presented.

Top module: `sysctl_clkregs`

## Requirements
- R1: After reset, every readable status, mask and configuration word is zero, except two. The primary clock word reads PRI_RST (default 0x078E3AD1). The second clock word reads SEC_RST (default 0x07802810) in the newer class. The interrupt output is low and the period output equals the period that the reset words give.
- R2: Offsets 0x000, 0x004, 0x008, 0x010, 0x014, 0x018 and 0x01C return the parameters ID0, ID1, CAP0, CAP1, CAP2, CAP3 and CAP4 in that order. Writes to these offsets change nothing.
- R3: Written data is kept only in the low bits of four words: 16 bits at offset 0x030, 5 bits at 0x034, 6 bits at 0x05C and 7 bits for the interrupt mask at 0x054. All upper bits read as zero.
- R4: Offset 0x050 reads the 7-bit raw status. Offset 0x058 reads the raw status ANDed with the mask. A write to 0x058 clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R5: The interrupt output is 1 exactly when the status ANDed with the mask is nonzero.
- R6: A write to the primary clock word (0x060) sets status bit 6 when the stored bit 13 is 1 and the written bit 13 is 0. Other combinations of bit 13 do not set it.
- R7: In the newer class, the second clock word (0x070) is fully writable and follows the same bit 13 falling-edge rule for status bit 6.
- R8: The period output equals 5 × (divider + 1). The divider comes from bits 28:23 of the second word when bit 31 of that word is 1, and from bits 26:23 of the primary word otherwise. The output changes one clock after the edge that stores the write.
- R9: Offset 0x064 reads a PLL word computed from idx = primary bits 9:6. In the newer class it is 0x1B00 + idx × 0x101. In the older class it is 0x1A00 + idx × 0x11.
- R10: In the older class, the second word reads zero and writes to it are ignored. Such writes never set a status bit and never change the period.
- R11: Reads of any other address, misaligned addresses included, return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt, masked status nonzero |
| sysclk_period_ns | output | PERIOD_W | Registered system clock period in ns |

## Verification
The bench builds two instances that share one stimulus stream. The first uses NEW_CLASS=1, where the override bit can hand the period to the six-bit divider and raise the largest period of 320 ns. The second uses NEW_CLASS=0, where the same writes to the second word must leave no trace. The two instances carry different identification parameters, so a swapped or wrongly masked identification read stands out. Since the PLL formulas differ per class, the same primary word read through both instances covers both table variants.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int STAT_W    = 7;
    localparam int BOR_W     = 16;
    localparam int LDO_W     = 5;
    localparam int RC_W      = 6;
    localparam int PWRDN_BIT = 13;
    localparam int OVR_BIT   = 31;
    localparam int LOCK_BIT  = 6;
    localparam int PDIV_LO   = 23;
    localparam int PDIV_W    = 4;
    localparam int SDIV_W    = 6;
    localparam int XTAL_LO   = 6;
    localparam int XTAL_W    = 4;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_ID0, SEL_ID1, SEL_CAP0, SEL_CAP1, SEL_CAP2, SEL_CAP3,
        SEL_CAP4, SEL_BOR, SEL_LDO, SEL_RAW, SEL_MASK, SEL_MSKD, SEL_RCAUSE,
        SEL_PRI, SEL_PLL, SEL_SEC
    } reg_sel_e;

    typedef struct packed {
        logic            wr;
        reg_sel_e        sel;
        logic [31:0]     data;
    } wreq_t;

    typedef struct packed {
        logic [BOR_W-1:0] bor;
        logic [LDO_W-1:0] ldo;
        logic [RC_W-1:0]  rcause;
        logic [31:0]      pri;
        logic [31:0]      sec;
    } cfg_t;

    function automatic reg_sel_e decode_off(input logic [11:0] off);
        reg_sel_e s;
        case (off)
            12'h000: s = SEL_ID0;
            12'h004: s = SEL_ID1;
            12'h008: s = SEL_CAP0;
            12'h010: s = SEL_CAP1;
            12'h014: s = SEL_CAP2;
            12'h018: s = SEL_CAP3;
            12'h01C: s = SEL_CAP4;
            12'h030: s = SEL_BOR;
            12'h034: s = SEL_LDO;
            12'h050: s = SEL_RAW;
            12'h054: s = SEL_MASK;
            12'h058: s = SEL_MSKD;
            12'h05C: s = SEL_RCAUSE;
            12'h060: s = SEL_PRI;
            12'h064: s = SEL_PLL;
            12'h070: s = SEL_SEC;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [31:0] period_of(input logic [PDIV_W-1:0] pdiv,
                                              input logic              ovr,
                                              input logic [SDIV_W-1:0] sdiv,
                                              input int unsigned       base);
        logic [31:0] div;
        div = ovr ? 32'(sdiv) : 32'(pdiv);
        return 32'(base) * (div + 32'd1);
    endfunction

    function automatic logic [31:0] pll_word(input bit newer,
                                             input logic [XTAL_W-1:0] idx);
        if (newer)
            return 32'h0000_1B00 + 32'(idx) * 32'h0000_0101;
        else
            return 32'h0000_1A00 + 32'(idx) * 32'h0000_0011;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    logic hi_ok;

    generate
        if (ADDR_W > 12) begin : g_wide
            assign hi_ok = (addr[ADDR_W-1:12] == '0);
        end else begin : g_narrow
            assign hi_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (hi_ok) sel = decode_off(addr[11:0]);
    end
endmodule

// File: rtl/sysctl_cfg.sv
module sysctl_cfg
    import sysctl_pkg::*;
#(
    parameter bit          NEW_CLASS = 1'b1,
    parameter logic [31:0] PRI_RST   = 32'h078E_3AD1,
    parameter logic [31:0] SEC_RST   = 32'h0780_2810
) (
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req,
    output cfg_t  cfg,
    output logic  lock_evt
);
    logic [BOR_W-1:0] bor_q;
    logic [LDO_W-1:0] ldo_q;
    logic [RC_W-1:0]  rc_q;
    logic [31:0]      pri_q;
    logic [31:0]      sec_q;
    logic             pri_fall;
    logic             sec_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            bor_q <= '0;
            ldo_q <= '0;
            rc_q  <= '0;
            pri_q <= PRI_RST;
        end else if (req.wr) begin
            case (req.sel)
                SEL_BOR:    bor_q <= req.data[BOR_W-1:0];
                SEL_LDO:    ldo_q <= req.data[LDO_W-1:0];
                SEL_RCAUSE: rc_q  <= req.data[RC_W-1:0];
                SEL_PRI:    pri_q <= req.data;
                default: ;
            endcase
        end
    end

    assign pri_fall = req.wr && (req.sel == SEL_PRI)
                   && pri_q[PWRDN_BIT] && !req.data[PWRDN_BIT];

    generate
        if (NEW_CLASS) begin : g_sec
            always_ff @(posedge clk) begin
                if (rst)
                    sec_q <= SEC_RST;
                else if (req.wr && req.sel == SEL_SEC)
                    sec_q <= req.data;
            end
            assign sec_fall = req.wr && (req.sel == SEL_SEC)
                           && sec_q[PWRDN_BIT] && !req.data[PWRDN_BIT];
        end else begin : g_nosec
            assign sec_q    = '0;
            assign sec_fall = 1'b0;
        end
    endgenerate

    assign lock_evt = pri_fall | sec_fall;

    always_comb begin
        cfg        = '0;
        cfg.bor    = bor_q;
        cfg.ldo    = ldo_q;
        cfg.rcause = rc_q;
        cfg.pri    = pri_q;
        cfg.sec    = sec_q;
    end
endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] wdata,
    input  logic              lock_evt,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);
    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] set_bits;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        set_bits = '0;
        set_bits[LOCK_BIT] = lock_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | set_bits;
            if (mask_we) mask_q <= wdata;
        end
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/sysctl_period.sv
module sysctl_period
    import sysctl_pkg::*;
#(
    parameter int          PERIOD_W   = 16,
    parameter int unsigned BASE_NS    = 5,
    parameter logic [31:0] RST_PERIOD = 32'd80
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PDIV_W-1:0]   pdiv,
    input  logic                ovr,
    input  logic [SDIV_W-1:0]   sdiv,
    output logic [PERIOD_W-1:0] period
);
    always_ff @(posedge clk) begin
        if (rst)
            period <= PERIOD_W'(RST_PERIOD);
        else
            period <= PERIOD_W'(period_of(pdiv, ovr, sdiv, BASE_NS));
    end
endmodule

// File: rtl/sysctl_clkregs.sv
module sysctl_clkregs
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          PERIOD_W  = 16,
    parameter int unsigned BASE_NS   = 5,
    parameter bit          NEW_CLASS = 1'b1,
    parameter logic [31:0] ID0       = 32'h0,
    parameter logic [31:0] ID1       = 32'h0,
    parameter logic [31:0] CAP0      = 32'h0,
    parameter logic [31:0] CAP1      = 32'h0,
    parameter logic [31:0] CAP2      = 32'h0,
    parameter logic [31:0] CAP3      = 32'h0,
    parameter logic [31:0] CAP4      = 32'h0,
    parameter logic [31:0] PRI_RST   = 32'h078E_3AD1,
    parameter logic [31:0] SEC_RST   = 32'h0780_2810
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq,
    output logic [PERIOD_W-1:0] sysclk_period_ns
);
    localparam logic [31:0] SEC_EFF    = NEW_CLASS ? SEC_RST : 32'h0;
    localparam logic [31:0] RST_PERIOD = period_of(PRI_RST[PDIV_LO +: PDIV_W],
                                                   SEC_EFF[OVR_BIT],
                                                   SEC_EFF[PDIV_LO +: SDIV_W],
                                                   BASE_NS);

    reg_sel_e          sel;
    wreq_t             req;
    cfg_t              cfg;
    logic              lock_evt;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;
    logic [31:0]       pri_q;
    logic [31:0]       sec_q;
    logic [31:0]       pll_rd;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        req.wr   = bus_wr;
        req.sel  = sel;
        req.data = bus_wdata;
    end

    sysctl_cfg #(
        .NEW_CLASS (NEW_CLASS),
        .PRI_RST   (PRI_RST),
        .SEC_RST   (SEC_RST)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cfg      (cfg),
        .lock_evt (lock_evt)
    );

    assign pri_q = cfg.pri;
    assign sec_q = cfg.sec;

    sysctl_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_we  (bus_wr && sel == SEL_MASK),
        .clr_we   (bus_wr && sel == SEL_MSKD),
        .wdata    (bus_wdata[STAT_W-1:0]),
        .lock_evt (lock_evt),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    sysctl_period #(
        .PERIOD_W   (PERIOD_W),
        .BASE_NS    (BASE_NS),
        .RST_PERIOD (RST_PERIOD)
    ) u_per (
        .clk    (clk),
        .rst    (rst),
        .pdiv   (pri_q[PDIV_LO +: PDIV_W]),
        .ovr    (sec_q[OVR_BIT]),
        .sdiv   (sec_q[PDIV_LO +: SDIV_W]),
        .period (sysclk_period_ns)
    );

    generate
        if (NEW_CLASS) begin : g_pll_new
            assign pll_rd = pll_word(1'b1, pri_q[XTAL_LO +: XTAL_W]);
        end else begin : g_pll_old
            assign pll_rd = pll_word(1'b0, pri_q[XTAL_LO +: XTAL_W]);
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_ID0:    bus_rdata = ID0;
            SEL_ID1:    bus_rdata = ID1;
            SEL_CAP0:   bus_rdata = CAP0;
            SEL_CAP1:   bus_rdata = CAP1;
            SEL_CAP2:   bus_rdata = CAP2;
            SEL_CAP3:   bus_rdata = CAP3;
            SEL_CAP4:   bus_rdata = CAP4;
            SEL_BOR:    bus_rdata = 32'(cfg.bor);
            SEL_LDO:    bus_rdata = 32'(cfg.ldo);
            SEL_RAW:    bus_rdata = 32'(stat_q);
            SEL_MASK:   bus_rdata = 32'(mask_q);
            SEL_MSKD:   bus_rdata = 32'(stat_q & mask_q);
            SEL_RCAUSE: bus_rdata = 32'(cfg.rcause);
            SEL_PRI:    bus_rdata = pri_q;
            SEL_PLL:    bus_rdata = pll_rd;
            SEL_SEC:    bus_rdata = sec_q;
            default:    bus_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/sysctl_clkregs_chk.sv
module sysctl_clkregs_chk #(
    parameter int ADDR_W    = 12,
    parameter int PERIOD_W  = 16,
    parameter bit NEW_CLASS = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                irq,
    input logic [PERIOD_W-1:0] sysclk_period_ns,
    input logic [31:0]         pri_q,
    input logic [31:0]         sec_q,
    input logic [6:0]          stat_q
);
    a_r6_lock_event: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(12'h060) && pri_q[13] && !bus_wdata[13])
        |=> stat_q[6]);

    a_r4_clear_on_one: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(12'h058) && bus_wdata[6]) |=> !stat_q[6]);

    a_r8_period_hold: assert property (@(posedge clk) disable iff (rst)
        ($stable(pri_q) && $stable(sec_q)) |=> $stable(sysclk_period_ns));

    a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != 7'd0));

    a_r3_mask_width: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(12'h054)) |-> (bus_rdata[31:7] == 25'd0));

    a_r10_old_second_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (!NEW_CLASS && bus_addr == ADDR_W'(12'h070)) |-> (bus_rdata == 32'h0));

    a_r11_misaligned_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[1:0] != 2'b00)
        |=> ($stable(pri_q) && $stable(sec_q) && $stable(stat_q)));
endmodule

bind sysctl_clkregs sysctl_clkregs_chk #(
    .ADDR_W    (ADDR_W),
    .PERIOD_W  (PERIOD_W),
    .NEW_CLASS (NEW_CLASS)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_addr         (bus_addr),
    .bus_wr           (bus_wr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .irq              (irq),
    .sysclk_period_ns (sysclk_period_ns),
    .pri_q            (pri_q),
    .sec_q            (sec_q),
    .stat_q           (stat_q)
);

// File: tb/sysctl_clkregs_test.sv
module sysctl_clkregs_test;
    localparam int CLK_NS = 10;
    localparam logic [31:0] PRI_R = 32'h078E_3AD1;
    localparam logic [31:0] SEC_R = 32'h0780_2810;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_n, rd_o;
    logic        irq_n, irq_o;
    logic [15:0] per_n, per_o;

    always #(CLK_NS/2) clk = ~clk;

    sysctl_clkregs #(.NEW_CLASS(1'b1), .ID0(32'h1001_0203), .ID1(32'h2002_1111),
        .CAP0(32'h00FF_007F), .CAP1(32'h0001_3333), .CAP2(32'h0F0F_1111),
        .CAP3(32'hA5A5_0000), .CAP4(32'h1000_007F)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rd_n), .irq(irq_n), .sysclk_period_ns(per_n));

    sysctl_clkregs #(.NEW_CLASS(1'b0), .ID0(32'h0000_0101), .ID1(32'h3003_2222),
        .CAP0(32'h001F_001F), .CAP1(32'h0000_1234), .CAP2(32'h0707_0000),
        .CAP3(32'h5A5A_FFFF), .CAP4(32'h0000_001F)) uut_old (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rd_o), .irq(irq_o), .sysclk_period_ns(per_o));

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] m_bor;
    logic [4:0]  m_ldo;
    logic [5:0]  m_rc;
    logic [6:0]  m_mask, m_stat_n, m_stat_o;
    logic [31:0] m_pri, m_sec;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] id_of(input bit newer, input logic [11:0] a);
        case (a)
            12'h000: return newer ? 32'h1001_0203 : 32'h0000_0101;
            12'h004: return newer ? 32'h2002_1111 : 32'h3003_2222;
            12'h008: return newer ? 32'h00FF_007F : 32'h001F_001F;
            12'h010: return newer ? 32'h0001_3333 : 32'h0000_1234;
            12'h014: return newer ? 32'h0F0F_1111 : 32'h0707_0000;
            12'h018: return newer ? 32'hA5A5_0000 : 32'h5A5A_FFFF;
            default: return newer ? 32'h1000_007F : 32'h0000_001F;
        endcase
    endfunction

    function automatic logic [31:0] exp_period(input logic [31:0] p, input logic [31:0] s);
        if (s[31]) return 32'd5 * ({26'd0, s[28:23]} + 32'd1);
        return 32'd5 * ({28'd0, p[26:23]} + 32'd1);
    endfunction

    function automatic logic [31:0] exp_rd(input bit newer, input logic [11:0] a);
        logic [6:0] st;
        logic [31:0] idx;
        st  = newer ? m_stat_n : m_stat_o;
        idx = {28'd0, m_pri[9:6]};
        case (a)
            12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018, 12'h01C:
                return id_of(newer, a);
            12'h030: return {16'd0, m_bor};
            12'h034: return {27'd0, m_ldo};
            12'h050: return {25'd0, st};
            12'h054: return {25'd0, m_mask};
            12'h058: return {25'd0, st & m_mask};
            12'h05C: return {26'd0, m_rc};
            12'h060: return m_pri;
            12'h064: return newer ? (32'h1B00 + idx * 32'h101) : (32'h1A00 + idx * 32'h11);
            12'h070: return newer ? m_sec : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input bit newer, input logic [11:0] a);
        case (a)
            12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018, 12'h01C: return "R2 id read";
            12'h030, 12'h034, 12'h054, 12'h05C: return "R3 masked word";
            12'h050, 12'h058: return "R4 status read";
            12'h060: return "R6 primary word";
            12'h064: return "R9 pll word";
            12'h070: return newer ? "R7 second word" : "R10 second word old";
            default: return "R11 undefined read";
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h030: m_bor = d[15:0];
            12'h034: m_ldo = d[4:0];
            12'h054: m_mask = d[6:0];
            12'h058: begin m_stat_n &= ~d[6:0]; m_stat_o &= ~d[6:0]; end
            12'h05C: m_rc = d[5:0];
            12'h060: begin
                if (m_pri[13] && !d[13]) begin
                    m_stat_n[6] = 1'b1;
                    m_stat_o[6] = 1'b1;
                end
                m_pri = d;
            end
            12'h070: begin
                if (m_sec[13] && !d[13]) m_stat_n[6] = 1'b1;
                m_sec = d;
            end
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1;
        wr = 1'b0;
        model_write(a, d);
        @(negedge clk);
    endtask

    task automatic read_chk(input logic [11:0] a);
        addr = a;
        #1;
        chk(req_of(1'b1, a), rd_n, exp_rd(1'b1, a));
        chk(req_of(1'b0, a), rd_o, exp_rd(1'b0, a));
    endtask

    task automatic state_chk();
        chk("R5 irq new", {31'd0, irq_n}, {31'd0, |(m_stat_n & m_mask)});
        chk("R5 irq old", {31'd0, irq_o}, {31'd0, |(m_stat_o & m_mask)});
        chk("R8 period new", {16'd0, per_n}, exp_period(m_pri, m_sec));
        chk("R10 period old", {16'd0, per_o}, exp_period(m_pri, 32'h0));
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [20];
        void'($urandom(32'd4711));
        offs = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018, 12'h01C,
                 12'h030, 12'h034, 12'h050, 12'h054, 12'h058, 12'h05C, 12'h060,
                 12'h064, 12'h070, 12'h00C, 12'h068, 12'h061, 12'h100};
        m_bor = '0; m_ldo = '0; m_rc = '0; m_mask = '0;
        m_stat_n = '0; m_stat_o = '0; m_pri = PRI_R; m_sec = SEC_R;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset period", {16'd0, per_n}, 32'd80);
        chk("R1 reset irq", {31'd0, irq_n}, 32'd0);
        addr = 12'h070; #1 chk("R1 reset second word", rd_n, SEC_R);
        addr = 12'h060; #1 chk("R1 reset primary word", rd_o, PRI_R);
        for (int i = 0; i < 16; i++) read_chk(offs[i]);

        // R2 identification words ignore writes
        do_write(12'h000, 32'hDEAD_BEEF);
        do_write(12'h01C, 32'h0);
        read_chk(12'h000); read_chk(12'h01C);

        // R3 write masks
        do_write(12'h030, 32'hFFFF_FFFF);
        do_write(12'h034, 32'hFFFF_FFFF);
        do_write(12'h05C, 32'hFFFF_FFFF);
        do_write(12'h054, 32'hFFFF_FFFF);
        addr = 12'h030; #1 chk("R3 bor width", rd_n, 32'h0000_FFFF);
        addr = 12'h034; #1 chk("R3 ldo width", rd_n, 32'h0000_001F);
        addr = 12'h05C; #1 chk("R3 rcause width", rd_n, 32'h0000_003F);
        addr = 12'h054; #1 chk("R3 mask width", rd_n, 32'h0000_007F);

        // R8 latency: divider 2, bit 13 stays set
        do_write(12'h060, 32'h0100_2000);
        chk("R8 period before update", {16'd0, per_n}, 32'd80);
        @(negedge clk);
        chk("R8 period after update", {16'd0, per_n}, 32'd15);

        // R6 lock event, R5 mask gating, R4 clear
        do_write(12'h060, 32'h0100_0000);
        addr = 12'h050; #1 chk("R6 lock event raw", rd_n, 32'h40);
        chk("R5 irq with mask", {31'd0, irq_n}, 32'd1);
        do_write(12'h054, 32'h0);
        chk("R5 irq masked off", {31'd0, irq_n}, 32'd0);
        read_chk(12'h058);
        do_write(12'h054, 32'h40);
        addr = 12'h058; #1 chk("R4 masked read", rd_n, 32'h40);
        do_write(12'h058, 32'hFFFF_FFBF);
        addr = 12'h050; #1 chk("R4 clear keeps unselected", rd_n, 32'h40);
        do_write(12'h058, 32'h40);
        addr = 12'h050; #1 chk("R4 clear by one", rd_n, 32'h0);
        chk("R5 irq after clear", {31'd0, irq_n}, 32'd0);
        do_write(12'h060, 32'h0100_0000);
        addr = 12'h050; #1 chk("R6 no event low to low", rd_n, 32'h0);
        do_write(12'h060, 32'h0100_2000);
        addr = 12'h050; #1 chk("R6 no event low to high", rd_n, 32'h0);

        // R7 / R10 second word
        do_write(12'h070, 32'h8080_2000);
        @(negedge clk);
        chk("R7 override period", {16'd0, per_n}, 32'd10);
        chk("R10 old period ignores second", {16'd0, per_o}, 32'd15);
        do_write(12'h070, 32'h8080_0000);
        addr = 12'h050; #1 chk("R7 second word lock event", rd_n, 32'h40);
        chk("R10 old no lock event", rd_o, 32'h0);
        addr = 12'h070; #1 chk("R10 old reads zero", rd_o, 32'h0);
        do_write(12'h070, 32'h9F80_0000);
        @(negedge clk);
        chk("R8 largest divider", {16'd0, per_n}, 32'd320);
        do_write(12'h058, 32'h7F);

        // R9 crystal index extremes
        do_write(12'h060, 32'h0000_23C0);
        addr = 12'h064; #1 chk("R9 pll new idx15", rd_n, 32'h0000_2A0F);
        chk("R9 pll old idx15", rd_o, 32'h0000_1AFF);
        do_write(12'h060, 32'h0000_2000);
        addr = 12'h064; #1 chk("R9 pll new idx0", rd_n, 32'h0000_1B00);

        // R11 undefined addresses
        do_write(12'h00C, 32'hFFFF_FFFF);
        do_write(12'h061, 32'h0000_0000);
        do_write(12'h068, 32'hFFFF_FFFF);
        read_chk(12'h00C); read_chk(12'h061); read_chk(12'h068); read_chk(12'h060);
        state_chk();

        // constrained random phase
        for (int it = 0; it < 400; it++) begin
            logic [11:0] a;
            logic [31:0] d;
            a = offs[$urandom_range(19, 0)];
            if ($urandom_range(3, 0) == 0) a = 12'h060;
            d = $urandom;
            do_write(a, d);
            @(negedge clk);
            state_chk();
            read_chk(offs[$urandom_range(19, 0)]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule